// File: doc/BRIEF.md
# Bus Cycle Halt Controller

This block sits between the cycle sequencer of a simple bus master and the external bus. The sequencer asks to open a bus cycle, and the controller either grants that start or holds it back. When the active-low halt line is pulled low, the cycle already on the bus runs to its end. After that no new cycle is granted, and the address and data output enables drop so that the bus drivers float.

Halt can also step the bus one cycle at a time. The stepping logic counts the falling edges of the synchronized halt level. Each new assertion of halt admits exactly one bus cycle. A cycle counts if it starts during the short release before the edge, or if it starts on a step credit that the edge grants. Holding halt low never admits a second cycle.

The same pin is open drain. A fatal error request makes the block pull the line low itself. The block then stays stopped until reset, and it does not read its own low drive as a step request.

Top module: `bus_halt_ctrl`

## Requirements
- R1: After reset the halt drive output is 0, no cycle start is issued without a request, and every address and data output enable bit is 1.
- R2: While halt is released, a request with no cycle open is granted in the same clock. The cycle stays open until the done strobe, and the next start comes one clock after done. With requests held, cycles of L busy clocks start every L+1 clocks.
- R3: The halt input takes effect two clocks after it changes, through a two-stage synchronizer. A cycle already open when halt is asserted runs to its done strobe with its output enables still high.
- R4: While halt is asserted, no cycle is open and none is starting, so all address and data output enables are 0.
- R5: Each falling edge of the synchronized halt admits exactly one bus cycle. That is either the cycle started during the release just before the edge, or a single later cycle granted by a step credit. Halt held low admits no more.
- R6: Releasing halt restores free-running behaviour, with the same cadence as R2.
- R7: A one-clock fatal error pulse sets the halt drive output to 1 (pull the line low) from the next clock. It stays 1 until reset.
- R8: In the error state no cycle start is issued and, once idle, all output enables are 0, whatever the halt input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_n_i | input | 1 | Halt line as seen at the pin, active low |
| halt_drive_o | output | 1 | 1 = pull the open-drain halt line low (error report) |
| fatal_err_i | input | 1 | Fatal error request, one clock pulse |
| cyc_req_i | input | 1 | Sequencer asks to open a bus cycle |
| cyc_start_o | output | 1 | Cycle start granted this clock |
| cyc_done_i | input | 1 | Open bus cycle finishes this clock |
| addr_oe_o | output | ADDR_OE_W | Address driver enables, 0 = high impedance |
| data_oe_o | output | DATA_OE_W | Data lane driver enables, 0 = high impedance |

## Verification
The assertions check, on every clock, the rules that hold at each edge. An error pulse must raise the halt drive, and that drive must never fall again. No start may appear during error. A granted start must keep the bus enabled in the next clock. A start taken while halted must use up the step credit. Only the bench scenarios can show the counted behaviours: the run cadence for each cycle length, one cycle per halt edge across pulse widths and request timings, a cycle finishing across a halt assertion, and the halt line being ignored once the block drives it itself.

// File: rtl/bhc_pkg.sv
package bhc_pkg;
   localparam int BHC_MIN_SYNC = 2;

   typedef struct packed {
      logic run;     // synchronized halt released
      logic credit;  // one stepped cycle may start
   } bhc_step_t;
endpackage

// File: rtl/bhc_sync.sv
module bhc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   localparam int LAST = STAGES - 1;

   if (STAGES < bhc_pkg::BHC_MIN_SYNC) begin : g_bad_stages
      $error("bhc_sync: STAGES must be at least 2");
   end

   logic [LAST:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_VAL;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= RST_VAL;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_o = chain_q[LAST];
endmodule

// File: rtl/bhc_step.sv
module bhc_step
   import bhc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      halt_rel_i,  // synchronized, 1 = released
   input  logic      start_i,     // cycle start granted this clock
   output bhc_step_t step_o
);
   logic prev_q;
   logic ran_q;
   logic credit_q;
   logic rise, fall;

   assign rise = halt_rel_i & ~prev_q;
   assign fall = prev_q & ~halt_rel_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= halt_rel_i;
   end

   // remembers whether the latest release window already ran a cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       ran_q <= 1'b0;
      else if (rise)                    ran_q <= start_i;
      else if (start_i && halt_rel_i)   ran_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                credit_q <= 1'b0;
      else if (halt_rel_i)       credit_q <= 1'b0;
      else if (fall && !ran_q)   credit_q <= 1'b1;
      else if (start_i)          credit_q <= 1'b0;
   end

   assign step_o.run    = halt_rel_i;
   assign step_o.credit = credit_q;

   // R5
   credit_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !halt_rel_i) |=> !credit_q);
endmodule

// File: rtl/bhc_gate.sv
module bhc_gate
   import bhc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_i,
   input  logic      done_i,
   input  logic      stop_i,   // sticky error stop
   input  bhc_step_t step_i,
   output logic      start_o,
   output logic      oe_o
);
   logic busy_q;

   assign start_o = req_i & ~busy_q & ~stop_i & (step_i.run | step_i.credit);
   assign oe_o    = busy_q | start_o | (step_i.run & ~stop_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              busy_q <= 1'b0;
      else if (start_o)        busy_q <= 1'b1;
      else if (busy_q && done_i) busy_q <= 1'b0;
   end

   // R2
   start_keeps_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> oe_o);
   // R4
   halted_idle_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !step_i.run && !step_i.credit) |-> !oe_o);
endmodule

// File: rtl/bus_halt_ctrl.sv
module bus_halt_ctrl
   import bhc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_OE_W   = 1,
   parameter int DATA_OE_W   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 halt_n_i,
   output logic                 halt_drive_o,
   input  logic                 fatal_err_i,
   input  logic                 cyc_req_i,
   output logic                 cyc_start_o,
   input  logic                 cyc_done_i,
   output logic [ADDR_OE_W-1:0] addr_oe_o,
   output logic [DATA_OE_W-1:0] data_oe_o
);
   if (ADDR_OE_W < 1 || DATA_OE_W < 1) begin : g_bad_width
      $error("bus_halt_ctrl: enable widths must be at least 1");
   end

   logic      err_q;
   logic      halt_rel_s;
   logic      bus_oe;
   bhc_step_t step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= err_q | fatal_err_i;
   end

   assign halt_drive_o = err_q;

   bhc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (halt_n_i),
      .q_o   (halt_rel_s)
   );

   bhc_step u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .halt_rel_i (halt_rel_s),
      .start_i    (cyc_start_o),
      .step_o     (step)
   );

   bhc_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (cyc_req_i),
      .done_i  (cyc_done_i),
      .stop_i  (err_q),
      .step_i  (step),
      .start_o (cyc_start_o),
      .oe_o    (bus_oe)
   );

   for (genvar a = 0; a < ADDR_OE_W; a++) begin : g_addr_oe
      assign addr_oe_o[a] = bus_oe;
   end
   for (genvar d = 0; d < DATA_OE_W; d++) begin : g_data_oe
      assign data_oe_o[d] = bus_oe;
   end

   // R7
   err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fatal_err_i |=> halt_drive_o);
   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_drive_o |=> halt_drive_o);
   // R8
   err_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_drive_o |-> !cyc_start_o);
endmodule

// File: tb/bus_halt_ctrl_tb_top.sv
module bus_halt_ctrl_tb_top;
   localparam int AW = 1;
   localparam int DW = 2;
   localparam int W  = 24;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ext_halt_n;
   logic          fatal_err;
   logic          req;
   logic          done;
   wire           halt_pin_n;
   wire           drive;
   wire           start;
   wire [AW-1:0]  addr_oe;
   wire [DW-1:0]  data_oe;

   int n_cmp = 0;
   int n_bad = 0;
   int n_start = 0;
   int cyc_len = 2;
   int remain = 0;
   bit ended = 0;

   always #2 clk = ~clk;

   // open-drain line: external pull-down or the block's own drive
   assign halt_pin_n = ext_halt_n & ~drive;

   bus_halt_ctrl #(.SYNC_STAGES(2), .ADDR_OE_W(AW), .DATA_OE_W(DW)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .halt_n_i     (halt_pin_n),
      .halt_drive_o (drive),
      .fatal_err_i  (fatal_err),
      .cyc_req_i    (req),
      .cyc_start_o  (start),
      .cyc_done_i   (done),
      .addr_oe_o    (addr_oe),
      .data_oe_o    (data_oe)
   );

   // bus responder: a granted cycle lasts cyc_len busy clocks
   always @(negedge clk) begin
      if (remain > 0) begin
         remain = remain - 1;
         done   = (remain == 0);
      end else begin
         done = 1'b0;
      end
      if (start) begin
         n_start = n_start + 1;
         remain  = cyc_len;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic run_window(input string tag, input int len);
      cyc_len = len;
      @(posedge clk); #1;
      n_start = 0;
      req = 1'b1;
      repeat (W) @(posedge clk);
      #1 req = 1'b0;
      check(tag, n_start, (W - 1) / (len + 1) + 1);
      repeat (len + 3) @(posedge clk);
   endtask

   initial begin
      #(4 * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; req = 1'b0; fatal_err = 1'b0; ext_halt_n = 1'b1; done = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 drive", drive, 0);
      check("R1 start", start, 0);
      check("R1 addr_oe", addr_oe, (1 << AW) - 1);
      check("R1 data_oe", data_oe, (1 << DW) - 1);

      // R2 cadence sweep
      for (int l = 1; l <= 4; l++) run_window("R2 cadence", l);

      // R3 open cycle finishes across halt assertion
      cyc_len = 4;
      @(posedge clk); #1;
      n_start = 0; req = 1'b1; ext_halt_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R3 oe while busy", addr_oe, (1 << AW) - 1);
      repeat (10) @(negedge clk);
      check("R3 one cycle", n_start, 1);
      check("R4 addr float", addr_oe, 0);
      check("R4 data float", data_oe, 0);

      // R5 stepping sweep: mode 0 request held, mode 1 request after edge
      for (int mode = 0; mode < 2; mode++)
         for (int h = 1; h <= 2; h++)
            for (int l = 1; l <= 4; l++)
               for (int n = 1; n <= 3; n++) begin
                  cyc_len = l;
                  @(posedge clk); #1;
                  req = (mode == 0);
                  n_start = 0;
                  for (int p = 0; p < n; p++) begin
                     ext_halt_n = 1'b1;
                     repeat (h) @(posedge clk);
                     #1 ext_halt_n = 1'b0;
                     repeat (3) @(posedge clk);
                     #1 if (mode == 1) req = 1'b1;
                     repeat (l + 6) @(posedge clk);
                     #1 if (mode == 1) req = 1'b0;
                  end
                  repeat (6) @(negedge clk);
                  check("R5 one cycle per edge", n_start, n);
                  check("R4 float after step", data_oe, 0);
               end

      // R6 resume
      req = 1'b0; ext_halt_n = 1'b1;
      repeat (4) @(posedge clk);
      run_window("R6 resume", 2);
      run_window("R6 resume", 3);

      // R7 / R8 error report
      cyc_len = 2;
      @(posedge clk); #1 fatal_err = 1'b1;
      @(posedge clk); #1 fatal_err = 1'b0;
      @(negedge clk);
      check("R7 drive raised", drive, 1);
      @(posedge clk); #1;
      n_start = 0; req = 1'b1;
      for (int t = 0; t < 4; t++) begin
         ext_halt_n = 1'b0;
         repeat (2) @(posedge clk);
         #1 ext_halt_n = 1'b1;
         repeat (3) @(posedge clk);
         #1;
      end
      repeat (4) @(negedge clk);
      check("R8 no start", n_start, 0);
      check("R8 addr float", addr_oe, 0);
      check("R8 data float", data_oe, 0);
      check("R7 drive sticky", drive, 1);

      // reset clears error
      req = 1'b0;
      @(posedge clk); #1 rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 drive after reset", drive, 0);
      check("R1 oe after reset", data_oe, (1 << DW) - 1);
      run_window("R2 after reset", 1);

      finish_run();
   end
endmodule